// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns parallel characters into asynchronous serial frames on a single output line. Each frame begins with a low start bit. The data bits follow, least significant first, then an optional parity bit, and then one or two high stop bits. When no frame is being sent, the line rests high. Timing comes from a 16x oversampling enable, so every bit lasts sixteen enable pulses. The enable can come from an internal programmable divider of the system clock, or from an external clock that runs at sixteen times the bit rate.

The host writes characters into a one-entry holding stage. At the start of each frame the character moves into a shift stage. The host can therefore supply the next character while the current one is still on the line, and consecutive frames follow each other with no idle time between them. Two flags report progress: one shows that the holding stage is empty, and the other shows that the transmitter has finished all work. When the internal timing source is selected, an optional bit-rate clock output is also available. It is low for the first half of each transmitted bit and rises at the middle of the bit.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, `txd` is 1, `sclk_out` is 1, `hold_empty` is 1 and `tx_end` is 1.
- R2: A frame is a start bit of 0, then the data bits with bit 0 first, then the parity bit if it is enabled, then the stop bits of 1. Each bit lasts exactly 16 timing enables.
- R3: When `len8` is 1, the frame carries `wr_data[7:0]`. When `len8` is 0, it carries only `wr_data[6:0]`, and bit 7 has no effect on the line.
- R4: When `par_en` is 1, a parity bit follows the data. Its value is the XOR of the sent data bits when `par_odd` is 0 (even), and the inverse of that XOR when `par_odd` is 1 (odd). When `par_en` is 0, no parity bit is sent.
- R5: When `two_stop` is 0, the frame has one stop bit. When `two_stop` is 1, it has two.
- R6: When `use_ext` is 0, a timing enable occurs once every `baud_div`+1 system clocks, so one bit lasts 16*(`baud_div`+1) clocks.
- R7: When `use_ext` is 1, a timing enable occurs on each rising edge of `ext_clk16`, so one bit lasts 16 periods of that clock.
- R8: A character written while a frame is being sent starts immediately after the last stop bit, with no idle time in between.
- R9: A write is accepted only while `hold_empty` is 1, and accepting it clears `hold_empty`. A write made while `hold_empty` is 0 is ignored. `hold_empty` returns to 1 in the cycle a character moves into the shift stage, which is the cycle its start bit begins.
- R10: A write clears `tx_end`. `tx_end` becomes 1 when the last stop bit ends and no character is waiting. While `tx_end` is 1, the line is high.
- R11: When `clk_out_en` is 1 and `use_ext` is 0, `sclk_out` is 0 for the first 8 enables of each frame bit and 1 for the last 8. It is 1 while the transmitter is idle. It is always 1 when `clk_out_en` is 0 or `use_ext` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| use_ext | input | 1 | 1 selects the external 16x clock; 0 selects the internal divider |
| ext_clk16 | input | 1 | External clock at 16x the bit rate |
| baud_div | input | DIV_W | Divider value N; one enable every N+1 clocks |
| len8 | input | 1 | 1 for 8 data bits, 0 for 7 data bits |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | Parity sense: 1 for odd, 0 for even |
| two_stop | input | 1 | 1 for two stop bits, 0 for one |
| clk_out_en | input | 1 | Enables the bit-rate clock output |
| wr_valid | input | 1 | Write strobe for a character |
| wr_data | input | 8 | Character to send |
| hold_empty | output | 1 | Holding stage can accept a character |
| tx_end | output | 1 | All frames sent and nothing waiting |
| txd | output | 1 | Serial data line |
| sclk_out | output | 1 | Bit-rate clock output, rising at mid-bit |

## Verification
The assertions check the following on every cycle:
- The line and the clock output are high whenever the transmitter reports it has finished.
- The clock output stays quiet whenever it is disabled or the external clock is selected.
- The data line changes only on a timing enable.
- `hold_empty` falls only after a write, and `tx_end` is never set while a character is waiting.

The bench scenarios cover what the assertions cannot:
- The exact bit sequence for each data length, parity setting and stop-bit setting.
- Bit durations under both timing sources.
- Back-to-back frames with no gap between them.
- That a write made while the holding stage is full is dropped.
- Where the rising edge of the clock output falls within each bit.

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_ext,
  input  logic             ext_clk16,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             len8,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             two_stop,
  input  logic             clk_out_en,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             hold_empty,
  output logic             tx_end,
  output logic             txd,
  output logic             sclk_out
);

  logic [DIV_W-1:0] div_cnt;
  logic [2:0]       ext_q;
  logic             tick;
  logic [7:0]       hold_q;
  logic             hold_full;
  logic             busy;
  logic [3:0]       sub;
  logic [3:0]       bits_left;
  logic [10:0]      shreg;
  logic             last_end;
  logic             load;

  function automatic logic [10:0] build_payload(input logic [7:0] d, input logic l8,
                                                input logic pen, input logic odd);
    logic [10:0] p;
    logic        par;
    p   = '1;
    par = ^(l8 ? d : {1'b0, d[6:0]}) ^ odd;
    if (l8) begin
      p[7:0] = d;
      if (pen) p[8] = par;
    end else begin
      p[6:0] = d[6:0];
      if (pen) p[7] = par;
    end
    return p;
  endfunction

  assign tick       = use_ext ? (ext_q[1] & ~ext_q[2]) : (div_cnt == '0);
  assign last_end   = busy && tick && sub == 4'd15 && bits_left == 4'd0;
  assign load       = tick && hold_full && (!busy || last_end);
  assign hold_empty = ~hold_full;
  assign sclk_out   = (clk_out_en && !use_ext && busy) ? sub[3] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      ext_q   <= '0;
    end else begin
      ext_q   <= {ext_q[1:0], ext_clk16};
      div_cnt <= (div_cnt == '0) ? baud_div : div_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      busy      <= 1'b0;
      sub       <= '0;
      bits_left <= '0;
      shreg     <= '1;
      txd       <= 1'b1;
      tx_end    <= 1'b1;
    end else begin
      if (load) begin
        txd       <= 1'b0;
        shreg     <= build_payload(hold_q, len8, par_en, par_odd);
        bits_left <= 4'd8 + {3'd0, len8} + {3'd0, par_en} + {3'd0, two_stop};
        sub       <= '0;
        busy      <= 1'b1;
        hold_full <= 1'b0;
      end else if (busy && tick) begin
        sub <= sub + 1'b1;
        if (sub == 4'd15) begin
          if (bits_left != 4'd0) begin
            txd       <= shreg[0];
            shreg     <= {1'b1, shreg[10:1]};
            bits_left <= bits_left - 1'b1;
          end else begin
            busy   <= 1'b0;
            txd    <= 1'b1;
            tx_end <= 1'b1;
          end
        end
      end
      if (wr_valid && !hold_full) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
        tx_end    <= 1'b0;
      end
    end
  end

endmodule

module serial_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic use_ext,
  input logic clk_out_en,
  input logic wr_valid,
  input logic tick,
  input logic hold_empty,
  input logic tx_end,
  input logic txd,
  input logic sclk_out
);

  a_r10_end_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |-> (txd && sclk_out));

  a_r11_clock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_out_en || use_ext) |-> sclk_out);

  a_r2_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(tick));

  a_r9_accept_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_empty) |-> $past(wr_valid));

  a_r10_end_implies_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |-> hold_empty);

endmodule

bind serial_frame_tx serial_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .use_ext(use_ext), .clk_out_en(clk_out_en),
  .wr_valid(wr_valid), .tick(tick), .hold_empty(hold_empty), .tx_end(tx_end),
  .txd(txd), .sclk_out(sclk_out)
);

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        use_ext = 1'b0;
  logic        ext_clk16 = 1'b0;
  logic [11:0] baud_div = 12'd1;
  logic        len8 = 1'b1;
  logic        par_en = 1'b0;
  logic        par_odd = 1'b0;
  logic        two_stop = 1'b0;
  logic        clk_out_en = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        hold_empty, tx_end, txd, sclk_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  serial_frame_tx #(.DIV_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .use_ext(use_ext), .ext_clk16(ext_clk16),
    .baud_div(baud_div), .len8(len8), .par_en(par_en), .par_odd(par_odd),
    .two_stop(two_stop), .clk_out_en(clk_out_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .hold_empty(hold_empty), .tx_end(tx_end), .txd(txd),
    .sclk_out(sclk_out)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    repeat (2) @(negedge clk);
    ext_clk16 = ~ext_clk16;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic write_char(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_start(output int st);
    int n = 0;
    while (txd !== 1'b0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(txd === 1'b0, "R2 start bit seen", txd, 0);
    st = cyc;
  endtask

  function automatic int expected_bits(input logic [7:0] d, input bit l8, input bit pen,
                                       input bit odd, input bit two, output logic [12:0] b);
    int n = 0;
    int nd = l8 ? 8 : 7;
    logic par = odd;
    b = '1;
    b[n++] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      b[n++] = d[i];
      par ^= d[i];
    end
    if (pen) b[n++] = par;
    b[n++] = 1'b1;
    if (two) b[n++] = 1'b1;
    return n;
  endfunction

  task automatic check_frame(input int st, input logic [7:0] d, input int dv, input bit clk_chk,
                             input bit expect_end, input string tag);
    logic [12:0] b;
    int n = expected_bits(d, len8, par_en, par_odd, two_stop, b);
    for (int k = 0; k < n; k++) begin
      if (clk_chk) begin
        wait_cyc(st + (16*k + 4)*dv);
        chk(sclk_out === 1'b0, "R11 sclk low first half", sclk_out, 0);
      end
      wait_cyc(st + (16*k + 8)*dv);
      chk(txd === b[k], tag, txd, b[k]);
      if (clk_chk) begin
        wait_cyc(st + (16*k + 12)*dv);
        chk(sclk_out === 1'b1, "R11 sclk high second half", sclk_out, 1);
      end
    end
    wait_cyc(st + 16*n*dv - 1);
    chk(tx_end === 1'b0, "R10 tx_end low before last stop ends", tx_end, 0);
    wait_cyc(st + 16*n*dv);
    if (expect_end) begin
      chk(tx_end === 1'b1, "R10 tx_end set after last stop", tx_end, 1);
      chk(txd === 1'b1, "R10 line idle high", txd, 1);
      chk(sclk_out === 1'b1, "R11 sclk idle high", sclk_out, 1);
    end
  endtask

  task automatic t_reset;
    chk(txd === 1'b1, "R1 txd", txd, 1);
    chk(sclk_out === 1'b1, "R1 sclk_out", sclk_out, 1);
    chk(hold_empty === 1'b1, "R1 hold_empty", hold_empty, 1);
    chk(tx_end === 1'b1, "R1 tx_end", tx_end, 1);
  endtask

  task automatic t_even8;
    int st;
    use_ext = 0; baud_div = 12'd1; len8 = 1; par_en = 1; par_odd = 0;
    two_stop = 0; clk_out_en = 1;
    write_char(8'hB4);
    chk(hold_empty === 1'b0, "R9 write clears hold_empty", hold_empty, 0);
    chk(tx_end === 1'b0, "R10 write clears tx_end", tx_end, 0);
    wait_start(st);
    chk(hold_empty === 1'b1, "R9 hold_empty set at start", hold_empty, 1);
    check_frame(st, 8'hB4, 2, 1, 1, "R2 R4 R6 8-bit even parity bit");
  endtask

  task automatic t_odd7_two;
    int st;
    use_ext = 0; baud_div = 12'd3; len8 = 0; par_en = 1; par_odd = 1;
    two_stop = 1; clk_out_en = 0;
    write_char(8'hD5);
    wait_start(st);
    chk(sclk_out === 1'b1, "R11 sclk disabled", sclk_out, 1);
    check_frame(st, 8'hD5, 4, 0, 1, "R3 R4 R5 R6 7-bit odd two stop bit");
  endtask

  task automatic t_ext_nopar;
    int st;
    use_ext = 1; len8 = 1; par_en = 0; two_stop = 0; clk_out_en = 1;
    write_char(8'h3C);
    wait_start(st);
    chk(sclk_out === 1'b1, "R11 sclk quiet with external clock", sclk_out, 1);
    check_frame(st, 8'h3C, 4, 0, 1, "R7 R4 external no parity bit");
    use_ext = 0;
  endtask

  task automatic t_back_to_back;
    int st, nA;
    logic [12:0] b;
    baud_div = 12'd1; len8 = 1; par_en = 0; two_stop = 0; clk_out_en = 0;
    write_char(8'hA5);
    wait_start(st);
    chk(hold_empty === 1'b1, "R9 empty after transfer", hold_empty, 1);
    write_char(8'h0F);
    chk(hold_empty === 1'b0, "R9 second write accepted", hold_empty, 0);
    write_char(8'hFF);
    nA = expected_bits(8'hA5, len8, par_en, par_odd, two_stop, b);
    check_frame(st, 8'hA5, 2, 0, 0, "R8 first frame bit");
    chk(txd === 1'b0, "R8 next start follows at once", txd, 0);
    chk(hold_empty === 1'b1, "R9 empty at second start", hold_empty, 1);
    check_frame(st + 16*nA*2, 8'h0F, 2, 0, 1, "R8 R9 second frame bit (write while full ignored)");
    repeat (400) @(negedge clk);
    chk(txd === 1'b1 && tx_end === 1'b1, "R9 ignored write sent nothing", txd, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_even8();
    t_odd7_two();
    t_ext_nopar();
    t_back_to_back();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule